// File: doc/BRIEF.md
# Process-Tagged Translation Lookaside Buffer

This block turns a virtual address into a physical address through a small fully associative store of recent page mappings. The address is cut into a page number (upper bits) and a byte offset (lower `PAGE_BITS` bits). The page number and the current process tag are compared against every entry at once. On a match the stored frame number takes the place of the page number, and the offset is copied through unchanged. The result is combinational, so a lookup gets its answer in the cycle it is presented.

When nothing matches, the block raises a miss and presents the faulting page number. An external refill engine then walks the page table and writes the mapping through the fill port. A fill goes into the lowest-numbered empty slot. If every slot is occupied, it goes into the slot named by a round-robin pointer. Each entry is tagged with a process number, so a context switch can simply change `cur_pid` without losing the entries of other processes. A flush input clears everything when that tagging is not wanted.

Each entry also carries a write-protect flag and a dirty flag. A write that matches a protected page is reported as a protection fault and not as a translation. A write that matches an unprotected page marks that entry dirty.

Top module: `tlb_xlate`

## Requirements
- R1: On a hit, `paddr` equals the matching entry's frame number placed above the offset, i.e. `{frame, lk_vaddr[PAGE_BITS-1:0]}`.
- R2: The low `PAGE_BITS` bits of `paddr` on a hit are identical to the low `PAGE_BITS` bits of `lk_vaddr`.
- R3: A lookup hits only an entry that is valid and whose page number equals `lk_vaddr[VA_W-1:PAGE_BITS]` and whose process tag equals `cur_pid`. The same page under another process tag is a miss.
- R4: Results appear in the same cycle as `lk_valid`.
  - While `lk_valid` is 1, exactly one of `hit`, `miss` and `prot_fault` is 1.
  - While `lk_valid` is 0, all three are 0.
  - `paddr` is 0 whenever `hit` is 0.
- R5: On a miss, `miss_vpn` carries the looked-up page number. Otherwise `miss_vpn` is 0.
- R6: `flush` invalidates every entry from the next cycle on. A fill presented in the same cycle as `flush` is discarded.
- R7: A write lookup (`lk_write`=1) that matches an entry with write-protect set gives `prot_fault`=1, `hit`=0, `paddr`=0 and `ctl_wp`=1. It does not set the dirty flag.
- R8: A write lookup that hits an unprotected entry sets that entry's dirty flag, which is shown on `ctl_dirty` by later matching lookups. A read does not set it, and a fill writes it as 0.
- R9: After reset every entry is invalid (every lookup misses) and the replacement pointer is at slot 0.
- R10: A fill is written into the lowest-numbered invalid slot when one exists.
- R11: When all slots are valid, a fill replaces the slot at the round-robin pointer. The pointer then advances by one and wraps from `ENTRIES-1` to 0. Flush does not move it.
- R12: A fill affects lookups from the next cycle onward. A lookup in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | VA_W | Virtual address to translate |
| cur_pid | input | PID_W | Process tag of the running context |
| hit | output | 1 | Successful translation |
| miss | output | 1 | No matching entry |
| prot_fault | output | 1 | Write to a write-protected page |
| paddr | output | PA_W | Translated physical address |
| ctl_wp | output | 1 | Write-protect flag of the matched entry |
| ctl_dirty | output | 1 | Dirty flag of the matched entry |
| miss_vpn | output | VA_W-PAGE_BITS | Page number that missed |
| fill_en | input | 1 | Install a mapping |
| fill_vpn | input | VA_W-PAGE_BITS | Page number to install |
| fill_pid | input | PID_W | Process tag to install |
| fill_pfn | input | PA_W-PAGE_BITS | Frame number to install |
| fill_wp | input | 1 | Write-protect flag to install |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with a 16-bit virtual address, 1024-byte pages, a 14-bit physical address, a 3-bit process tag and four entries. The physical frame field is therefore 4 bits wide, narrower than the 6-bit page field, which exposes width slips between the two sides of the translation. With only four slots and page numbers drawn from a small set, the array fills up within a few cycles. This brings round-robin wrap-around, replacement of dirty and protected entries, and fill-versus-lookup collisions into reach many times per run. Rare flushes leave the pointer in a non-zero position, which separates the empty-slot-first rule from the pointer rule.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Per-entry control flags reported alongside a match.
  typedef struct packed {
    logic wp;
    logic dirty;
  } tlb_ctl_t;

  // Index width that stays legal for a single-entry array.
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int VPN_W = 6,
  parameter int PID_W = 3,
  parameter int PFN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_wp,
  input  logic             mark_dirty,
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [PID_W-1:0] key_pid,
  output logic             match,
  output logic             valid_o,
  output logic [PFN_W-1:0] pfn_o,
  output tlb_ctl_t         ctl_o
);

  logic             valid_q, valid_d;
  logic [VPN_W-1:0] vpn_q, vpn_d;
  logic [PID_W-1:0] pid_q, pid_d;
  logic [PFN_W-1:0] pfn_q, pfn_d;
  tlb_ctl_t         ctl_q, ctl_d;
  logic             ld_en;

  // Priority: flush, then fill, then dirty marking.
  always_comb begin
    valid_d = valid_q;
    vpn_d   = vpn_q;
    pid_d   = pid_q;
    pfn_d   = pfn_q;
    ctl_d   = ctl_q;
    if (flush) begin
      valid_d = 1'b0;
    end else if (wr_en) begin
      valid_d     = 1'b1;
      vpn_d       = wr_vpn;
      pid_d       = wr_pid;
      pfn_d       = wr_pfn;
      ctl_d.wp    = wr_wp;
      ctl_d.dirty = 1'b0;
    end else if (mark_dirty) begin
      ctl_d.dirty = 1'b1;
    end
  end

  assign ld_en = flush | wr_en | mark_dirty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      pid_q   <= '0;
      pfn_q   <= '0;
      ctl_q   <= '0;
    end else if (ld_en) begin
      valid_q <= valid_d;
      vpn_q   <= vpn_d;
      pid_q   <= pid_d;
      pfn_q   <= pfn_d;
      ctl_q   <= ctl_d;
    end
  end

  assign match   = valid_q && (vpn_q == key_vpn) && (pid_q == key_pid);
  assign valid_o = valid_q;
  assign pfn_o   = pfn_q;
  assign ctl_o   = ctl_q;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_en,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] sel_vec
);

  localparam int IDX_W = idx_width(ENTRIES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx, pick_idx;
  logic             any_free;
  logic             take;
  logic             ptr_en;

  // Lowest-numbered empty slot.
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign take     = fill_en && !flush;
  assign pick_idx = any_free ? free_idx : ptr_q;
  assign ptr_en   = take && !any_free;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  always_comb begin
    sel_vec = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      sel_vec[i] = take && (pick_idx == IDX_W'(i));
    end
  end

endmodule

// File: rtl/tlb_hit_mux.sv
module tlb_hit_mux #(
  parameter int ENTRIES = 4,
  parameter int PFN_W   = 4
) (
  input  logic [ENTRIES-1:0]            match_vec,
  input  logic [ENTRIES-1:0][PFN_W-1:0] pfn_arr,
  input  logic [ENTRIES-1:0]            wp_vec,
  input  logic [ENTRIES-1:0]            dirty_vec,
  output logic                          any_match,
  output logic [PFN_W-1:0]              pfn,
  output logic                          wp,
  output logic                          dirty
);

  // AND-OR selection; entries are kept unique by the refill engine.
  always_comb begin
    pfn   = '0;
    wp    = 1'b0;
    dirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      pfn   = pfn | (pfn_arr[i] & {PFN_W{match_vec[i]}});
      wp    = wp | (wp_vec[i] & match_vec[i]);
      dirty = dirty | (dirty_vec[i] & match_vec[i]);
    end
  end

  assign any_match = |match_vec;

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W      = 16,
  parameter int PA_W      = 14,
  parameter int PAGE_BITS = 10,
  parameter int PID_W     = 3,
  parameter int ENTRIES   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_valid,
  input  logic                      lk_write,
  input  logic [VA_W-1:0]           lk_vaddr,
  input  logic [PID_W-1:0]          cur_pid,
  output logic                      hit,
  output logic                      miss,
  output logic                      prot_fault,
  output logic [PA_W-1:0]           paddr,
  output logic                      ctl_wp,
  output logic                      ctl_dirty,
  output logic [VA_W-PAGE_BITS-1:0] miss_vpn,
  input  logic                      fill_en,
  input  logic [VA_W-PAGE_BITS-1:0] fill_vpn,
  input  logic [PID_W-1:0]          fill_pid,
  input  logic [PA_W-PAGE_BITS-1:0] fill_pfn,
  input  logic                      fill_wp,
  input  logic                      flush
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;

  // Reset synchronizer: asserts at once, releases on a clock edge.
  logic rst_s1, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_q <= rst_s1;
    end
  end

  logic [VPN_W-1:0]              key_vpn;
  logic [PAGE_BITS-1:0]          offset;
  logic [ENTRIES-1:0]            match_vec, valid_vec, wp_vec, dirty_vec, sel_vec;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_arr;
  logic                          any_match, m_wp, m_dirty;
  logic [PFN_W-1:0]              m_pfn;
  logic                          do_fault;

  assign key_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
  assign offset  = lk_vaddr[PAGE_BITS-1:0];

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .fill_en   (fill_en),
    .flush     (flush),
    .valid_vec (valid_vec),
    .sel_vec   (sel_vec)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    tlb_ctl_t ctl;
    logic     mark;
    assign mark = lk_valid && lk_write && match_vec[g] && !ctl.wp;

    tlb_entry #(.VPN_W(VPN_W), .PID_W(PID_W), .PFN_W(PFN_W)) u_ent (
      .clk        (clk),
      .rst_n      (rst_sync_q),
      .flush      (flush),
      .wr_en      (sel_vec[g]),
      .wr_vpn     (fill_vpn),
      .wr_pid     (fill_pid),
      .wr_pfn     (fill_pfn),
      .wr_wp      (fill_wp),
      .mark_dirty (mark),
      .key_vpn    (key_vpn),
      .key_pid    (cur_pid),
      .match      (match_vec[g]),
      .valid_o    (valid_vec[g]),
      .pfn_o      (pfn_arr[g]),
      .ctl_o      (ctl)
    );

    assign wp_vec[g]    = ctl.wp;
    assign dirty_vec[g] = ctl.dirty;
  end

  tlb_hit_mux #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_mux (
    .match_vec (match_vec),
    .pfn_arr   (pfn_arr),
    .wp_vec    (wp_vec),
    .dirty_vec (dirty_vec),
    .any_match (any_match),
    .pfn       (m_pfn),
    .wp        (m_wp),
    .dirty     (m_dirty)
  );

  assign do_fault   = lk_valid && any_match && lk_write && m_wp;
  assign hit        = lk_valid && any_match && !do_fault;
  assign prot_fault = do_fault;
  assign miss       = lk_valid && !any_match;
  assign paddr      = hit ? {m_pfn, offset} : '0;
  assign ctl_wp     = lk_valid && m_wp;
  assign ctl_dirty  = lk_valid && m_dirty;
  assign miss_vpn   = miss ? key_vpn : '0;

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int VA_W      = 16,
  parameter int PA_W      = 14,
  parameter int PAGE_BITS = 10
) (
  input logic                      clk,
  input logic                      rst_ok,
  input logic                      lk_valid,
  input logic                      lk_write,
  input logic [VA_W-1:0]           lk_vaddr,
  input logic                      hit,
  input logic                      miss,
  input logic                      prot_fault,
  input logic [PA_W-1:0]           paddr,
  input logic                      ctl_wp,
  input logic [VA_W-PAGE_BITS-1:0] miss_vpn,
  input logic                      flush
);

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    lk_valid |-> $countones({hit, miss, prot_fault}) == 1);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    !lk_valid |-> !(hit || miss || prot_fault));

  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_ok)
    hit |-> paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

  assert_no_paddr_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    !hit |-> paddr == '0);

  assert_miss_page_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    miss |-> miss_vpn == lk_vaddr[VA_W-1:PAGE_BITS]);

  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    prot_fault |-> (lk_write && ctl_wp));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    flush |=> !(hit || prot_fault));

endmodule

bind tlb_xlate tlb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_q),
  .lk_valid   (lk_valid),
  .lk_write   (lk_write),
  .lk_vaddr   (lk_vaddr),
  .hit        (hit),
  .miss       (miss),
  .prot_fault (prot_fault),
  .paddr      (paddr),
  .ctl_wp     (ctl_wp),
  .miss_vpn   (miss_vpn),
  .flush      (flush)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;
  localparam int VA_W = 16, PA_W = 14, PAGE_BITS = 10, PID_W = 3, ENTRIES = 4;
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, lk_valid, lk_write, fill_en, fill_wp, flush;
  logic [VA_W-1:0]  lk_vaddr;
  logic [PID_W-1:0] cur_pid, fill_pid;
  logic [VPN_W-1:0] fill_vpn, miss_vpn;
  logic [PFN_W-1:0] fill_pfn;
  logic hit, miss, prot_fault, ctl_wp, ctl_dirty;
  logic [PA_W-1:0] paddr;

  tlb_xlate #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PID_W(PID_W),
              .ENTRIES(ENTRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_write(lk_write),
    .lk_vaddr(lk_vaddr), .cur_pid(cur_pid), .hit(hit), .miss(miss),
    .prot_fault(prot_fault), .paddr(paddr), .ctl_wp(ctl_wp), .ctl_dirty(ctl_dirty),
    .miss_vpn(miss_vpn), .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
    .fill_pfn(fill_pfn), .fill_wp(fill_wp), .flush(flush)
  );

  int n_chk = 0, n_bad = 0;

  // Reference state built from the requirements.
  logic             mv  [ENTRIES];
  logic [VPN_W-1:0] mvpn[ENTRIES];
  logic [PID_W-1:0] mpid[ENTRIES];
  logic [PFN_W-1:0] mpfn[ENTRIES];
  logic             mwp [ENTRIES];
  logic             md  [ENTRIES];
  int               mptr;

  task automatic chk(input string r, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic int find_entry(input logic [VPN_W-1:0] vpn, input logic [PID_W-1:0] pid);
    int f = -1;
    for (int i = 0; i < ENTRIES; i++)
      if (mv[i] && mvpn[i] == vpn && mpid[i] == pid) f = i;
    return f;
  endfunction

  function automatic int pick_slot();
    int v = -1;
    for (int i = ENTRIES - 1; i >= 0; i--) if (!mv[i]) v = i;
    return v;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < ENTRIES; i++) begin
      mv[i] = 1'b0; md[i] = 1'b0; mwp[i] = 1'b0;
      mvpn[i] = '0; mpid[i] = '0; mpfn[i] = '0;
    end
    mptr = 0;
  endtask

  task automatic step(input string r, input logic lv, input logic lw,
                      input logic [VA_W-1:0] va, input logic [PID_W-1:0] pid,
                      input logic fe, input logic [VPN_W-1:0] fvpn,
                      input logic [PID_W-1:0] fpid, input logic [PFN_W-1:0] fpfn,
                      input logic fwp, input logic fl);
    int h, v;
    logic e_hit, e_flt, e_miss;
    logic [PA_W-1:0] e_pa;
    @(negedge clk);
    lk_valid = lv; lk_write = lw; lk_vaddr = va; cur_pid = pid;
    fill_en = fe; fill_vpn = fvpn; fill_pid = fpid; fill_pfn = fpfn;
    fill_wp = fwp; flush = fl;
    #5;
    h      = find_entry(va[VA_W-1:PAGE_BITS], pid);
    e_flt  = lv && h >= 0 && lw && mwp[h];
    e_hit  = lv && h >= 0 && !e_flt;
    e_miss = lv && h < 0;
    e_pa   = e_hit ? {mpfn[h], va[PAGE_BITS-1:0]} : '0;
    chk(r, "hit", 32'(hit), 32'(e_hit));
    chk(r, "miss", 32'(miss), 32'(e_miss));
    chk(r, "prot_fault", 32'(prot_fault), 32'(e_flt));
    chk(r, "paddr", 32'(paddr), 32'(e_pa));
    chk(r, "miss_vpn", 32'(miss_vpn), e_miss ? 32'(va[VA_W-1:PAGE_BITS]) : 32'd0);
    if (lv && h >= 0) begin
      chk(r, "ctl_wp", 32'(ctl_wp), 32'(mwp[h]));
      chk(r, "ctl_dirty", 32'(ctl_dirty), 32'(md[h]));
    end
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < ENTRIES; i++) mv[i] = 1'b0;
    end else begin
      if (lv && lw && h >= 0 && !mwp[h]) md[h] = 1'b1;
      if (fe) begin
        v = pick_slot();
        if (v < 0) begin
          v = mptr;
          mptr = (mptr + 1) % ENTRIES;
        end
        mv[v] = 1'b1; mvpn[v] = fvpn; mpid[v] = fpid; mpfn[v] = fpfn;
        mwp[v] = fwp; md[v] = 1'b0;
      end
    end
  endtask

  function automatic logic [VA_W-1:0] mk_va(input int vpn, input int off);
    return {VPN_W'(vpn), PAGE_BITS'(off)};
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    rst_n = 1'b0; lk_valid = 0; lk_write = 0; lk_vaddr = '0; cur_pid = '0;
    fill_en = 0; fill_vpn = '0; fill_pid = '0; fill_pfn = '0; fill_wp = 0; flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R9: empty after reset
    step("R9", 1, 0, mk_va(5, 'h1de), 1, 0, 0, 0, 0, 0, 0);
    // R12: fill with same-cycle lookup sees the old contents
    step("R12", 1, 0, mk_va(5, 'h1de), 1, 1, 5, 1, 9, 0, 0);
    // R1 / R2: translation with the offset kept
    step("R1", 1, 0, mk_va(5, 'h1de), 1, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 0, mk_va(5, 'h3ff), 1, 0, 0, 0, 0, 0, 0);
    // R3: other process tag misses; R5 miss page
    step("R3", 1, 0, mk_va(5, 'h010), 2, 0, 0, 0, 0, 0, 0);
    step("R5", 1, 1, mk_va(33, 'h200), 1, 0, 0, 0, 0, 0, 0);
    // R8: read leaves dirty clear, write sets it
    step("R8", 1, 0, mk_va(5, 0), 1, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 1, mk_va(5, 4), 1, 0, 0, 0, 0, 0, 0);
    step("R8", 1, 0, mk_va(5, 8), 1, 0, 0, 0, 0, 0, 0);
    // R7: protected page
    step("R7", 0, 0, 0, 0, 1, 6, 1, 3, 1, 0);
    step("R7", 1, 1, mk_va(6, 'h55), 1, 0, 0, 0, 0, 0, 0);
    step("R7", 1, 0, mk_va(6, 'h55), 1, 0, 0, 0, 0, 0, 0);
    // R4: idle cycle
    step("R4", 0, 1, mk_va(6, 1), 1, 0, 0, 0, 0, 0, 0);
    // R11: fill up, then round-robin from slot 0
    step("R10", 0, 0, 0, 0, 1, 1, 1, 7, 0, 0);
    step("R10", 0, 0, 0, 0, 1, 2, 1, 8, 0, 0);
    step("R11", 0, 0, 0, 0, 1, 3, 1, 10, 0, 0);
    step("R11", 1, 0, mk_va(5, 0), 1, 0, 0, 0, 0, 0, 0);
    step("R11", 1, 0, mk_va(6, 0), 1, 0, 0, 0, 0, 0, 0);
    // R6: flush beats a same-cycle fill
    step("R6", 0, 0, 0, 0, 1, 4, 1, 2, 0, 1);
    step("R6", 1, 0, mk_va(4, 0), 1, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 0, mk_va(6, 0), 1, 0, 0, 0, 0, 0, 0);
    // R10: empty slots first although the pointer now sits at 1
    for (int k = 0; k < ENTRIES; k++) step("R10", 0, 0, 0, 0, 1, VPN_W'(10 + k), 2, PFN_W'(k), 0, 0);
    step("R11", 0, 0, 0, 0, 1, 14, 2, 15, 0, 0);
    step("R10", 1, 0, mk_va(10, 3), 2, 0, 0, 0, 0, 0, 0);
    step("R11", 1, 0, mk_va(11, 3), 2, 0, 0, 0, 0, 0, 0);
    step("R11", 1, 0, mk_va(14, 3), 2, 0, 0, 0, 0, 0, 0);

    // Random mix, all requirements via the reference state
    for (int n = 0; n < 4000; n++) begin
      logic lv, lw, fe, fwp, fl;
      logic [VPN_W-1:0] fvpn;
      logic [PID_W-1:0] pid, fpid;
      logic [VA_W-1:0] va;
      lv   = ($urandom % 4) != 0;
      lw   = $urandom % 2;
      va   = mk_va($urandom % 8, $urandom % 1024);
      pid  = PID_W'($urandom % 3);
      fe   = ($urandom % 4) == 0;
      fvpn = VPN_W'($urandom % 8);
      fpid = PID_W'($urandom % 3);
      fwp  = ($urandom % 3) == 0;
      fl   = ($urandom % 97) == 0;
      if (fe && find_entry(fvpn, fpid) >= 0) fe = 1'b0;
      step("R4", lv, lw, va, pid, fe, fvpn, fpid, PFN_W'($urandom), fwp, fl);
    end
    finish_run();
  end
endmodule